// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block watches over a processor from inside the same clock domain. It takes a digital supply-health flag and a watchdog strobe, and it produces an active-low reset, the same reset in active-high form, a latched watchdog-fault flag, an undelayed low-supply flag and a chip-enable output. The chip-enable output stays inactive while the supply is bad.

Reset follows a bad supply at once. It is then stretched for a fixed number of clock cycles once the supply is good again. A watchdog fault launches the same full-length reset pulse. The processor services the watchdog by toggling the strobe, and both a rising and a falling transition count as a service. A select input picks a short or a long watchdog window. A disable input turns the watchdog off; it stands in for a strobe pin that is left floating. When reset begins while the memory enable is active, the enable is allowed to stay active for a short bounded hold so that a write cycle already under way can finish.

All time intervals are parameters in clock cycles: `RST_CYCLES`, `WD_FAST`, `WD_SLOW` and `CE_HOLD`. The inputs are taken to be synchronous to `clk`, except the strobe, which is synchronized inside the block.

Top module: `sup_wdog_top`

## Requirements
- R1: While `supply_ok` is 0, `reset_n_out` is 0 in the same cycle with no clock edge needed, and `low_line_n` equals `supply_ok` at all times.
- R2: When `supply_ok` returns to 1, `reset_n_out` stays 0 through the next `RST_CYCLES`-1 clock edges and becomes 1 after the `RST_CYCLES`-th edge.
- R3: `reset_out` is always the logical inverse of `reset_n_out`.
- R4: While `rst_n` is 0, reset is active, `wd_fault_n` is 1 and `ce_out_n` is 1. After `rst_n` returns to 1 with the supply good, reset is released after `RST_CYCLES` edges.
- R5: With the watchdog enabled and no strobe transition, counting starts at the edge after reset releases or the watchdog is enabled. `wd_fault_n` falls and reset asserts at the P-th edge, where P is `WD_FAST` when `wd_long_sel`=0 and `WD_SLOW` when `wd_long_sel`=1.
- R6: Strobe transitions of either polarity, spaced more closely than the watchdog period, prevent any fault or reset.
- R7: A watchdog fault holds reset for `RST_CYCLES` edges, and `wd_fault_n` stays 0 after that reset ends.
- R8: `wd_fault_n` returns to 1 on the third clock edge after a strobe transition of either polarity. The delay comes from a two-stage synchronizer plus edge detection.
- R9: While `wd_disable` is 1, `wd_fault_n` stays 1 and the watchdog causes no reset.
- R10: Outside a hold window, `ce_out_n` is 0 only when `ce_in_n` is 0 and reset is inactive.
- R11: If `ce_in_n` is 0 when reset asserts, `ce_out_n` stays 0 for `CE_HOLD` cycles, counted from the assertion to the `CE_HOLD`-th edge, and then goes to 1.
- R12: A hold window ends as soon as `ce_in_n` goes to 1, and `ce_out_n` does not fall again while reset remains active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all timing |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| supply_ok | input | 1 | Supply health, 1 = good |
| wd_strobe | input | 1 | Watchdog service strobe, asynchronous |
| wd_disable | input | 1 | 1 = watchdog off |
| wd_long_sel | input | 1 | 0 = short window, 1 = long window |
| ce_in_n | input | 1 | Chip-enable request, active low |
| reset_n_out | output | 1 | System reset, active low |
| reset_out | output | 1 | System reset, active high |
| wd_fault_n | output | 1 | Watchdog fault, active low, latched |
| low_line_n | output | 1 | Low-supply flag, active low |
| ce_out_n | output | 1 | Gated chip-enable, active low |

## Verification
The supply flag reaches `reset_n_out`, `low_line_n` and `ce_out_n` combinationally, so the bench samples these one nanosecond after changing it. The reset stretch releases exactly `RST_CYCLES` edges after the supply recovers or a fault occurs, and a watchdog trip comes P edges after counting starts. A strobe transition clears the fault on the third edge, because it passes two synchronizer flops and an edge register first. The bench drives and samples 2 ns after a rising edge. For each timed result it checks the value one edge before the due edge and again just after it, so an off-by-one in either direction shows up.

// File: rtl/sup_pkg.sv
// Package sup_pkg: shared helpers for the supervisor blocks.
// Assumes all counts passed in are at least 1.
package sup_pkg;

    // Number of bits needed to hold the values 0..n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Watchdog window choice.
    typedef enum logic {
        WD_SHORT = 1'b0,
        WD_LONG  = 1'b1
    } wd_window_e;

endpackage

// File: rtl/sup_wd_edge.sv
// sup_wd_edge: brings the asynchronous watchdog strobe into the clock
// domain through two flops. It then flags any change of level, rising or
// falling, as a one-cycle service pulse. Assumes the strobe stays at each
// level for at least two clocks.
module sup_wd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic svc_edge
);

    logic meta_q;
    logic sync_q;
    logic last_q;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= strobe;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign svc_edge = sync_q ^ last_q;

endmodule

// File: rtl/sup_wd_timer.sv
// sup_wd_timer: counts cycles since the last service pulse and raises a
// trip when the selected window runs out. The fault flag latches on a
// trip and clears only on a service pulse or when the watchdog is turned
// off. The counter is held at zero while reset is active.
module sup_wd_timer
    import sup_pkg::*;
#(
    parameter int WD_FAST = 160,
    parameter int WD_SLOW = 2560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic svc_edge,
    input  logic wd_disable,
    input  logic long_sel,
    input  logic hold_clr,
    output logic trip,
    output logic fault
);

    localparam int W = cnt_width(WD_SLOW);
    localparam logic [W-1:0] FAST_LAST = W'(WD_FAST - 1);
    localparam logic [W-1:0] SLOW_LAST = W'(WD_SLOW - 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] win_last;
    wd_window_e   window;

    assign window   = wd_window_e'(long_sel);
    assign win_last = (window == WD_LONG) ? SLOW_LAST : FAST_LAST;

    // Terminal count this cycle, unless something clears the counter first.
    assign trip = !rst_n ? 1'b0 :
                  (!svc_edge && !wd_disable && !hold_clr && (cnt_q >= win_last));

    // Window counter and latched fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            fault <= 1'b0;
        end else if (svc_edge || wd_disable) begin
            cnt_q <= '0;
            fault <= 1'b0;
        end else if (hold_clr) begin
            cnt_q <= '0;
        end else if (trip) begin
            cnt_q <= '0;
            fault <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_trip_sets_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> fault);
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SLOW_LAST);
    p_edge_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        svc_edge |=> !fault);
    p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_disable |=> (!fault && !trip));

endmodule

// File: rtl/sup_rst_stretch.sv
// sup_rst_stretch: holds reset active while the supply is bad or a
// watchdog trip arrives. Once those causes are gone, it keeps reset
// active for RST_CYCLES more clock edges. Assumes RST_CYCLES >= 1.
module sup_rst_stretch
    import sup_pkg::*;
#(
    parameter int RST_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic trip,
    output logic rst_active
);

    localparam int W = cnt_width(RST_CYCLES);
    localparam logic [W-1:0] RST_LAST = W'(RST_CYCLES - 1);

    logic [W-1:0] cnt_q;

    // Restart on any cause; count down the stretch once the causes clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok || trip) begin
            cnt_q      <= '0;
            rst_active <= 1'b1;
        end else if (rst_active) begin
            if (cnt_q == RST_LAST) begin
                cnt_q      <= '0;
                rst_active <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    p_supply_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> rst_active);
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RST_LAST);
    p_trip_resets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (rst_active && cnt_q == '0));

endmodule

// File: rtl/sup_ce_gate.sv
// sup_ce_gate: blocks the active-low chip enable while reset is active.
// If the enable is low at the moment reset begins, it keeps the enable
// low for up to CE_HOLD cycles, or until the request is withdrawn.
// Assumes CE_HOLD >= 1.
module sup_ce_gate
    import sup_pkg::*;
#(
    parameter int CE_HOLD = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_any,
    input  logic ce_in_n,
    output logic ce_out_n
);

    localparam int W = cnt_width(CE_HOLD);
    localparam logic [W-1:0] HOLD_LAST = W'(CE_HOLD - 1);
    localparam logic         MULTI     = (CE_HOLD > 1);

    logic         rst_seen_q;
    logic         hold_q;
    logic [W-1:0] hcnt_q;
    logic         hold_start;
    logic         hold_ok;

    assign hold_start = rst_n && rst_any && !rst_seen_q && !ce_in_n;
    assign hold_ok    = hold_start || hold_q;
    assign ce_out_n   = ce_in_n || (rst_any && !hold_ok);

    // Track reset history and time the bounded hold window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_seen_q <= 1'b1;
            hold_q     <= 1'b0;
            hcnt_q     <= '0;
        end else begin
            rst_seen_q <= rst_any;
            if (hold_start) begin
                hold_q <= MULTI;
                hcnt_q <= W'(1);
            end else if (hold_q && (ce_in_n || hcnt_q == HOLD_LAST)) begin
                hold_q <= 1'b0;
                hcnt_q <= '0;
            end else if (hold_q) begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end
    end

    p_ce_needs_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_out_n |-> !ce_in_n);
    p_hold_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (hcnt_q >= W'(1) && hcnt_q <= HOLD_LAST));
    p_hold_ends_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && ce_in_n) |=> !hold_q);

endmodule

// File: rtl/sup_wdog_top.sv
// sup_wdog_top: supervisor top. It joins the strobe edge detector, the
// watchdog timer, the reset stretcher and the chip-enable gate. Supply
// health reaches the reset, low-line and enable outputs without delay.
// Assumes supply_ok, wd_disable, wd_long_sel and ce_in_n are synchronous
// to clk.
module sup_wdog_top #(
    parameter int RST_CYCLES = 1000,
    parameter int WD_FAST    = 160,
    parameter int WD_SLOW    = 2560,
    parameter int CE_HOLD    = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic wd_strobe,
    input  logic wd_disable,
    input  logic wd_long_sel,
    input  logic ce_in_n,
    output logic reset_n_out,
    output logic reset_out,
    output logic wd_fault_n,
    output logic low_line_n,
    output logic ce_out_n
);

    logic svc_edge;
    logic trip;
    logic fault;
    logic rst_active;
    logic rst_any;

    sup_wd_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (wd_strobe),
        .svc_edge (svc_edge)
    );

    sup_wd_timer #(
        .WD_FAST (WD_FAST),
        .WD_SLOW (WD_SLOW)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .svc_edge   (svc_edge),
        .wd_disable (wd_disable),
        .long_sel   (wd_long_sel),
        .hold_clr   (rst_active),
        .trip       (trip),
        .fault      (fault)
    );

    sup_rst_stretch #(
        .RST_CYCLES (RST_CYCLES)
    ) u_stretch (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .trip       (trip),
        .rst_active (rst_active)
    );

    // Reset is active from any cause, including the power-on input itself.
    assign rst_any = rst_active || !supply_ok || !rst_n;

    sup_ce_gate #(
        .CE_HOLD (CE_HOLD)
    ) u_ce (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_any  (rst_any),
        .ce_in_n  (ce_in_n),
        .ce_out_n (ce_out_n)
    );

    assign reset_n_out = !rst_any;
    assign reset_out   = rst_any;
    assign wd_fault_n  = !(rst_n && fault);
    assign low_line_n  = supply_ok;

    p_fault_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_fault_n) |-> !reset_n_out);

endmodule

// File: tb/sim_sup_wdog_top.sv
// Directed bench for sup_wdog_top. Inputs are driven and outputs sampled
// 2 ns after each rising edge.
module sim_sup_wdog_top;

    localparam int CLK_PERIOD = 10;
    localparam int RST_C  = 8;
    localparam int FAST_C = 12;
    localparam int SLOW_C = 30;
    localparam int HOLD_C = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic wd_strobe = 1'b0;
    logic wd_disable = 1'b1;
    logic wd_long_sel = 1'b0;
    logic ce_in_n = 1'b1;
    logic reset_n_out, reset_out, wd_fault_n, low_line_n, ce_out_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sup_wdog_top #(
        .RST_CYCLES (RST_C),
        .WD_FAST    (FAST_C),
        .WD_SLOW    (SLOW_C),
        .CE_HOLD    (HOLD_C)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .wd_strobe   (wd_strobe),
        .wd_disable  (wd_disable),
        .wd_long_sel (wd_long_sel),
        .ce_in_n     (ce_in_n),
        .reset_n_out (reset_n_out),
        .reset_out   (reset_out),
        .wd_fault_n  (wd_fault_n),
        .low_line_n  (low_line_n),
        .ce_out_n    (ce_out_n)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_rst(input string req, input logic exp_n);
        check(req, "reset_n_out", reset_n_out, exp_n);
        check("R3", "reset_out inverse", reset_out, ~reset_n_out);
    endtask

    // R4: power-on reset state and stretch after release.
    task automatic t_power_on();
        step(3);
        check_rst("R4", 1'b0);
        check("R4", "wd_fault_n", wd_fault_n, 1'b1);
        check("R4", "ce_out_n", ce_out_n, 1'b1);
        rst_n = 1'b1;
        step(RST_C - 1);
        check_rst("R4", 1'b0);
        step(1);
        check_rst("R4", 1'b1);
    endtask

    // R1, R2: supply loss and recovery.
    task automatic t_supply();
        supply_ok = 1'b0;
        #1;
        check_rst("R1", 1'b0);
        check("R1", "low_line_n low", low_line_n, 1'b0);
        step(2);
        supply_ok = 1'b1;
        #1;
        check("R1", "low_line_n high", low_line_n, 1'b1);
        check_rst("R2", 1'b0);
        step(RST_C - 1);
        check_rst("R2", 1'b0);
        step(1);
        check_rst("R2", 1'b1);
    endtask

    // R10: plain chip-enable gating.
    task automatic t_ce_basic();
        ce_in_n = 1'b0;
        #1;
        check("R10", "ce_out_n follows low", ce_out_n, 1'b0);
        ce_in_n = 1'b1;
        #1;
        check("R10", "ce_out_n follows high", ce_out_n, 1'b1);
    endtask

    // R11: bounded hold when reset asserts with enable low.
    task automatic t_ce_hold();
        ce_in_n = 1'b0;
        step(1);
        supply_ok = 1'b0;
        #1;
        check("R11", "hold start", ce_out_n, 1'b0);
        step(HOLD_C - 1);
        check("R11", "hold last cycle", ce_out_n, 1'b0);
        step(1);
        check("R11", "hold over", ce_out_n, 1'b1);
        supply_ok = 1'b1;
        step(RST_C);
        check_rst("R2", 1'b1);
        check("R10", "ce_out_n after reset", ce_out_n, 1'b0);
        ce_in_n = 1'b1;
        step(1);
    endtask

    // R12: hold ends early when the request is withdrawn.
    task automatic t_ce_early();
        ce_in_n = 1'b0;
        step(1);
        supply_ok = 1'b0;
        step(1);
        ce_in_n = 1'b1;
        #1;
        check("R12", "early end", ce_out_n, 1'b1);
        step(1);
        ce_in_n = 1'b0;
        #1;
        check("R12", "no refall", ce_out_n, 1'b1);
        supply_ok = 1'b1;
        step(RST_C);
        ce_in_n = 1'b1;
        step(1);
    endtask

    // R9: disabled watchdog never faults.
    task automatic t_disable();
        step(SLOW_C * 3);
        check("R9", "wd_fault_n", wd_fault_n, 1'b1);
        check_rst("R9", 1'b1);
    endtask

    // R5, R7, R8: short window trip, fault pulse, rising-edge clear.
    task automatic t_wd_short();
        wd_long_sel = 1'b0;
        wd_disable = 1'b0;
        step(FAST_C - 1);
        check("R5", "no trip yet", wd_fault_n, 1'b1);
        step(1);
        check("R5", "short trip", wd_fault_n, 1'b0);
        check_rst("R5", 1'b0);
        step(RST_C - 1);
        check_rst("R7", 1'b0);
        step(1);
        check_rst("R7", 1'b1);
        check("R7", "fault stays latched", wd_fault_n, 1'b0);
        wd_strobe = 1'b1;
        step(2);
        check("R8", "not yet cleared", wd_fault_n, 1'b0);
        step(1);
        check("R8", "cleared by rise", wd_fault_n, 1'b1);
        wd_disable = 1'b1;
        step(2);
    endtask

    // R5, R8: long window trip and falling-edge clear.
    task automatic t_wd_long();
        wd_long_sel = 1'b1;
        wd_disable = 1'b0;
        step(SLOW_C - 1);
        check("R5", "no long trip yet", wd_fault_n, 1'b1);
        step(1);
        check("R5", "long trip", wd_fault_n, 1'b0);
        step(RST_C);
        check_rst("R7", 1'b1);
        wd_strobe = 1'b0;
        step(2);
        check("R8", "not yet cleared", wd_fault_n, 1'b0);
        step(1);
        check("R8", "cleared by fall", wd_fault_n, 1'b1);
        wd_disable = 1'b1;
        wd_long_sel = 1'b0;
        step(2);
    endtask

    // R6: regular toggling keeps the watchdog quiet.
    task automatic t_service();
        wd_disable = 1'b0;
        for (int i = 0; i < 12; i++) begin
            wd_strobe = ~wd_strobe;
            step(5);
            check("R6", "serviced fault", wd_fault_n, 1'b1);
            check_rst("R6", 1'b1);
        end
        wd_disable = 1'b1;
    endtask

    initial begin
        t_power_on();
        t_supply();
        t_ce_basic();
        t_ce_hold();
        t_ce_early();
        t_disable();
        t_wd_short();
        t_wd_long();
        t_service();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule